// File: doc/BRIEF.md
# GPIO Group Interrupt Controller

This block watches a set of general-purpose input pins, organised as groups of eight, and turns activity on them into interrupt requests. Each pin is given its own trigger condition: active-low level, active-high level, falling edge, rising edge or either edge. Qualifying events latch into a per-group pending register. A per-group mask register decides which pending bits may reach the processor, and all groups feed one shared interrupt line.

Every pin input passes through a two-stage synchronizer before it is evaluated. Edges are found by comparing the synchronized sample with the sample from the cycle before. Software reaches the three register banks (trigger configuration, mask, pending) through a simple single-cycle register bus. Reads return data on the cycle after the read strobe. An interrupt handler reads the pending bank, services the unmasked bits and acknowledges each one by writing a 1 to it.

Top module: `gpio_group_irq`

## Requirements
- R1: After reset every trigger field reads 0, every mask register reads 0x000000FF and `irq_out` is low.
- R2: Group g's trigger register is at address 0x700+4g, its mask register at 0x900+4g and its pending register at 0xA00+4g. The mask and pending registers hold the group's 8 pins in bits 7:0, and pin p is bit p.
- R3: Pin p's trigger type is the 4-bit field at bits 4p+3:4p of its group's trigger register. Only bits 4p+2:4p are stored, and bit 4p+3 always reads 0.
- R4: Trigger code 0 (level low) and code 1 (level high) set the pending bit on every cycle the synchronized pin holds the active level. While that level persists, a write-one-to-clear leaves the bit set.
- R5: Code 2 sets the pending bit on a 1-to-0 transition of the pin, code 3 on a 0-to-1 transition and code 4 on either transition. A pin that holds its value sets nothing.
- R6: Codes 5, 6 and 7 never set the pending bit.
- R7: Writing a 1 to a pending bit clears it unless a trigger event hits that bit in the same cycle. Writing a 0 leaves the bit unchanged.
- R8: A pending bit latches whether or not its mask bit is set. A mask bit of 1 only blocks the bit from reaching `irq_out`.
- R9: `irq_out` is high exactly when, one cycle earlier, some group had a bit that was both pending and unmasked (mask bit 0).
- R10: `bus_rdata` updates on the clock edge that samples `bus_rd`. Addresses outside the three banks, and addresses that are not word-aligned, read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_GROUPS*8 | Asynchronous pin inputs; group g, pin p is bit 8g+p |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Combined interrupt request, registered |

## Verification
Each random trial gives one pin a random trigger code and a random before/after pin value. The other pins in its group are parked on a code that raises no events, so the whole pending byte shows which transitions and held levels each code reacts to. Holding a pin steady against each edge code separates the level modes from the edge modes. Reserved codes with toggling pins separate "no event" from a misdecoded edge. Directed sequences then drive a single unmasked pin through masking, unmasking, write-zero and write-one acknowledges. These tell a pending bit that latches behind a mask apart from one that is gated by it, and a level that cannot be acknowledged apart from an edge that can.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;
  localparam int PINS_PER_GRP = 8;
  localparam int FIELD_W      = 4;
  localparam int CFG_BASE     = 'h700;
  localparam int MASK_BASE    = 'h900;
  localparam int PEND_BASE    = 'hA00;

  typedef enum logic [2:0] {
    TRIG_LOW  = 3'd0,
    TRIG_HIGH = 3'd1,
    TRIG_FALL = 3'd2,
    TRIG_RISE = 3'd3,
    TRIG_BOTH = 3'd4
  } trig_e;
endpackage

// File: rtl/gpirq_sync.sv
module gpirq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] cur,
  output logic [W-1:0] prv
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      cur    <= '0;
      prv    <= '0;
    end else begin
      meta_q <= d;
      cur    <= meta_q;
      prv    <= cur;
    end
  end
endmodule

// File: rtl/gpirq_detect.sv
module gpirq_detect
  import gpirq_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       cur,
  input  logic       prv,
  output logic       ev
);
  always_comb begin
    case (trig_e'(mode))
      TRIG_LOW:  ev = ~cur;
      TRIG_HIGH: ev = cur;
      TRIG_FALL: ev = prv & ~cur;
      TRIG_RISE: ev = ~prv & cur;
      TRIG_BOTH: ev = prv ^ cur;
      default:   ev = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpirq_group.sv
module gpirq_group
  import gpirq_pkg::*;
#(
  parameter int PINS = PINS_PER_GRP,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic            mask_we,
  input  logic            pend_we,
  input  logic [DW-1:0]   wdata,
  input  logic [PINS-1:0] cur,
  input  logic [PINS-1:0] prv,
  output logic [DW-1:0]   cfg_rd,
  output logic [PINS-1:0] mask_q,
  output logic [PINS-1:0] pend_q
);
  localparam int FW = DW / PINS;

  logic [2:0]      mode_q [PINS];
  logic [PINS-1:0] set_ev;
  logic [PINS-1:0] clr;

  genvar p;
  generate
    for (p = 0; p < PINS; p++) begin : g_pin
      always_ff @(posedge clk) begin
        if (rst)         mode_q[p] <= 3'd0;
        else if (cfg_we) mode_q[p] <= wdata[p*FW +: 3];
      end

      gpirq_detect u_det (
        .mode (mode_q[p]),
        .cur  (cur[p]),
        .prv  (prv[p]),
        .ev   (set_ev[p])
      );

      assign cfg_rd[p*FW +: FW] = {{(FW-3){1'b0}}, mode_q[p]};

      // R7: an acknowledge with no coincident event clears the bit
      p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (pend_q[p] && pend_we && wdata[p] && !set_ev[p]) |=> !pend_q[p]);
      // R4: an event beats a simultaneous acknowledge
      p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
        set_ev[p] |=> pend_q[p]);
      // R8: a clear bit never rises without an event, mask or not
      p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
        (!pend_q[p] && !set_ev[p]) |=> !pend_q[p]);
      // R6: reserved codes keep a clear bit clear
      p_reserved_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_q[p] > 3'd4 && !cfg_we && !pend_q[p]) |=> !pend_q[p]);
    end
  endgenerate

  assign clr = pend_we ? wdata[PINS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      if (mask_we) mask_q <= wdata[PINS-1:0];
      pend_q <= (pend_q & ~clr) | set_ev;
    end
  end
endmodule

// File: rtl/gpio_group_irq.sv
module gpio_group_irq
  import gpirq_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int ADDR_W     = 12
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_GROUPS*PINS_PER_GRP-1:0] pin_in,
  input  logic                           bus_wr,
  input  logic                           bus_rd,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [31:0]                    bus_wdata,
  output logic [31:0]                    bus_rdata,
  output logic                           irq_out
);
  localparam int PINS  = PINS_PER_GRP;
  localparam int NPINS = NUM_GROUPS * PINS;
  localparam int DW    = 32;

  logic [NPINS-1:0] cur, prv;
  logic [DW-1:0]    cfg_rd  [NUM_GROUPS];
  logic [PINS-1:0]  mask_q  [NUM_GROUPS];
  logic [PINS-1:0]  pend_q  [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] sel_cfg, sel_mask, sel_pend, grp_act;
  logic [DW-1:0]    rd_mux;
  logic             any_act;

  gpirq_sync #(.W(NPINS)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .cur (cur),
    .prv (prv)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : g_grp
      localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_BASE  + 4*g);
      localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_BASE + 4*g);
      localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(PEND_BASE + 4*g);

      assign sel_cfg[g]  = (bus_addr == A_CFG);
      assign sel_mask[g] = (bus_addr == A_MASK);
      assign sel_pend[g] = (bus_addr == A_PEND);

      gpirq_group #(.PINS(PINS), .DW(DW)) u_grp (
        .clk     (clk),
        .rst     (rst),
        .cfg_we  (bus_wr & sel_cfg[g]),
        .mask_we (bus_wr & sel_mask[g]),
        .pend_we (bus_wr & sel_pend[g]),
        .wdata   (bus_wdata),
        .cur     (cur[g*PINS +: PINS]),
        .prv     (prv[g*PINS +: PINS]),
        .cfg_rd  (cfg_rd[g]),
        .mask_q  (mask_q[g]),
        .pend_q  (pend_q[g])
      );

      assign grp_act[g] = |(pend_q[g] & ~mask_q[g]);
    end
  endgenerate

  assign any_act = |grp_act;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_GROUPS; i++) begin
      if (sel_cfg[i])  rd_mux = cfg_rd[i];
      if (sel_mask[i]) rd_mux = {{(DW-PINS){1'b0}}, mask_q[i]};
      if (sel_pend[i]) rd_mux = {{(DW-PINS){1'b0}}, pend_q[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      irq_out <= any_act;
    end
  end

  // R9: line follows the pending-and-unmasked state one cycle later
  p_irq_high_r9: assert property (@(posedge clk) disable iff (rst)
    any_act |=> irq_out);
  p_irq_low_r9: assert property (@(posedge clk) disable iff (rst)
    !any_act |=> !irq_out);
  // R10: read data is held between read strobes
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
  // R2: at most one register selected per address
  p_one_select_r2: assert property (@(posedge clk) disable iff (rst)
    $countones({sel_cfg, sel_mask, sel_pend}) <= 1);
endmodule

// File: tb/sim_gpio_group_irq.sv
module sim_gpio_group_irq;
  localparam int NG = 4;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NG*8-1:0] pin_in = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  gpio_group_irq #(.NUM_GROUPS(NG), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .pin_in(pin_in),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic exp_bit(input int mode, input logic o, input logic n);
    case (mode)
      0: return !o || !n;
      1: return o || n;
      2: return o && !n;
      3: return !o && n;
      4: return o != n;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] cfg_word(input int p, input int mode);
    return (32'h55555555 & ~(32'hF << (4*p))) | (32'(mode) << (4*p));
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int g, p, mode;
    logic o, n;
    void'($urandom(32'd1234));
    idle(3);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    check("R1 irq", {31'b0, irq_out}, 32'h0);
    for (int i = 0; i < NG; i++) begin
      rdreg(AW'('h700 + 4*i), rd); check("R1 cfg", rd, 32'h0);
      rdreg(AW'('h900 + 4*i), rd); check("R1 mask", rd, 32'hFF);
    end
    // park every group on a silent code
    for (int i = 0; i < NG; i++) wr(AW'('h700 + 4*i), 32'h55555555);

    // R5 R4 R6 random trigger trials
    for (int t = 0; t < 60; t++) begin
      g = $urandom % NG; p = $urandom % 8; mode = $urandom % 8;
      o = 1'($urandom % 2); n = 1'($urandom % 2);
      pin_in[g*8+p] = o;
      idle(5);
      wr(AW'('h700 + 4*g), cfg_word(p, mode));
      wr(AW'('hA00 + 4*g), 32'hFF);
      pin_in[g*8+p] = n;
      idle(6);
      rdreg(AW'('hA00 + 4*g), rd);
      check($sformatf("R5/R4/R6 mode %0d %0b->%0b", mode, o, n), rd,
            {24'b0, 8'(exp_bit(mode, o, n)) << p});
      wr(AW'('h700 + 4*g), 32'h55555555);
      pin_in[g*8+p] = 1'b0;
      idle(5);
      wr(AW'('hA00 + 4*g), 32'hFF);
    end

    // R9 R8 R7: group 2 pin 5 rising edge
    wr(12'h708, cfg_word(5, 3));
    wr(12'hA08, 32'hFF);
    wr(12'h908, 32'hDF);
    idle(2);
    check("R9 idle low", {31'b0, irq_out}, 32'h0);
    pin_in[21] = 1'b1;
    idle(6);
    check("R9 raised", {31'b0, irq_out}, 32'h1);
    wr(12'hA08, 32'h00);
    rdreg(12'hA08, rd); check("R7 write zero", rd, 32'h20);
    wr(12'h908, 32'hFF);
    idle(2);
    check("R9 masked low", {31'b0, irq_out}, 32'h0);
    rdreg(12'hA08, rd); check("R8 latched behind mask", rd, 32'h20);
    wr(12'h908, 32'hDF);
    idle(2);
    check("R9 unmask", {31'b0, irq_out}, 32'h1);
    wr(12'hA08, 32'h20);
    idle(2);
    check("R7 irq after ack", {31'b0, irq_out}, 32'h0);
    rdreg(12'hA08, rd); check("R7 ack clears", rd, 32'h0);
    // R8 edge while masked
    wr(12'h908, 32'hFF);
    pin_in[21] = 1'b0; idle(4); pin_in[21] = 1'b1; idle(6);
    rdreg(12'hA08, rd); check("R8 masked edge latches", rd, 32'h20);
    check("R8 masked no irq", {31'b0, irq_out}, 32'h0);
    wr(12'hA08, 32'hFF);

    // R4 level high cannot be acknowledged while held
    wr(12'h704, cfg_word(0, 1));
    pin_in[8] = 1'b1; idle(5);
    wr(12'hA04, 32'hFF);
    rdreg(12'hA04, rd); check("R4 level holds", rd, 32'h01);
    pin_in[8] = 1'b0; idle(5);
    wr(12'hA04, 32'hFF);
    rdreg(12'hA04, rd); check("R4 level released", rd, 32'h0);

    // R6 code 7 with toggling pin, R3 readback
    wr(12'h700, cfg_word(3, 7));
    wr(12'hA00, 32'hFF);
    for (int k = 0; k < 4; k++) begin pin_in[3] = ~pin_in[3]; idle(4); end
    rdreg(12'hA00, rd); check("R6 code 7 quiet", rd, 32'h0);
    rdreg(12'h700, rd); check("R3 readback", rd, 32'h55557555);

    // R3 top bit of each field is not stored
    wr(12'h70C, 32'hFFFFFFFF);
    rdreg(12'h70C, rd); check("R3 field width", rd, 32'h77777777);
    wr(12'h70C, 32'h55555555);

    // R2 R10 decode
    wr(12'h90C, 32'h0000005A);
    rdreg(12'h90C, rd); check("R2 mask g3", rd, 32'h5A);
    wr(12'h800, 32'hFFFFFFFF);
    rdreg(12'h800, rd); check("R10 unmapped", rd, 32'h0);
    wr(12'h701, 32'h0);
    rdreg(12'h701, rd); check("R10 misaligned read", rd, 32'h0);
    rdreg(12'h700, rd); check("R10 misaligned write ignored", rd, 32'h55557555);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule